// File: doc/BRIEF.md
# Packed Signed 16-bit Lane Multiplier with Pairwise Reduction

This unit treats each of two 64-bit operands as four signed 16-bit lanes and multiplies them lane by lane. A two-bit operation code selects one of three result formats: the low half of every 32-bit lane product, the high half of every lane product, or two 32-bit sums, each formed from a pair of neighbouring products. All three formats use the same four multipliers. The formatting step only picks or adds bits of their outputs.

The unit is fully pipelined. An operation is presented with a one-cycle strobe and comes out exactly two clock cycles later with its own strobe. A new operation may be issued in every cycle, and each one keeps its own operation code through the pipeline, so consecutive operations may use different formats. A synchronous active-low reset discards any operation that is still in flight.

Top module: `pmul_unit`

## Requirements
- R1: With op_in = 2'b00, result lane k (bits 16k+15 down to 16k, k = 0..3) holds bits 15:0 of the 32-bit signed product of operand lanes k.
- R2: With op_in = 2'b01, result lane k holds bits 31:16 of the 32-bit signed product of operand lanes k.
- R3: With op_in = 2'b10, result bits 31:0 hold the product of lanes 0 plus the product of lanes 1, and result bits 63:32 hold the product of lanes 2 plus the product of lanes 3.
- R4: The pair sums of R3 wrap modulo 2^32. When all four lanes of both operands are 16'h8000, each 32-bit half of the result is 32'h80000000.
- R5: With op_in = 2'b11 (reserved), the whole result is zero.
- R6: valid_out is high in exactly the cycle two rising edges after valid_in was sampled high, and at no other time. result_out is valid while valid_out is high.
- R7: Operations issued on consecutive cycles with different op_in values each produce the result of their own op_in and operands, one result per cycle, in issue order.
- R8: While rst_n is sampled low, the pipeline valid bits clear. valid_out is low after that edge, and operations in flight at the reset never appear.
- R9: Operand lanes are signed two's-complement. For example, 16'hFFFF times 16'h0001 gives a high half of 16'hFFFF, and 16'hFFFF times 16'hFFFF gives a low half of 16'h0001 and a high half of 16'h0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_in | input | 1 | Issue strobe for the operands and op_in |
| op_in | input | 2 | Result format: 00 low, 01 high, 10 pair sums, 11 zero |
| a_in | input | 64 | First operand, four signed 16-bit lanes |
| b_in | input | 64 | Second operand, four signed 16-bit lanes |
| valid_out | output | 1 | Result strobe, two cycles after valid_in |
| result_out | output | 64 | Formatted result |

## Verification
A wrong operation code or valid bit held in the middle stage shows up at the ports two cycles after issue. It appears either as a result in the wrong format on a cycle where the neighbouring operation used a different op_in, or as a strobe that is missing, extra or one cycle off. A corrupted product register shows up in the very next result as a wrong lane, and a wrong carry between lane products shows up as a wrong upper half of a pair sum. The scoreboard compares every result value and its arrival cycle. Mixed back-to-back formats, extreme lane values and a reset with an operation in flight expose each of these faults at the first output they affect.

// File: rtl/pmul_pkg.sv
// pmul_pkg: shared operation codes for the packed lane multiplier.
// Assumes a two-bit code; the fourth code is reserved and yields zero.
package pmul_pkg;
    typedef enum logic [1:0] {
        PM_LO   = 2'b00,
        PM_HI   = 2'b01,
        PM_MADD = 2'b10,
        PM_RSVD = 2'b11
    } pmul_op_e;
endpackage

// File: rtl/pmul_lane.sv
// pmul_lane: one signed LW x LW multiplier with a registered product.
// Assumes the caller enables it only on issued operations; the product
// register needs no reset because the valid pipeline qualifies it.
module pmul_lane #(
    parameter int LW = 16,
    localparam int PW = 2 * LW
) (
    input  logic                 clk,
    input  logic                 en,
    input  logic signed [LW-1:0] a,
    input  logic signed [LW-1:0] b,
    output logic signed [PW-1:0] prod_q
);
    // Capture the full-width signed product of an issued operation.
    always_ff @(posedge clk) begin
        if (en) begin
            prod_q <= a * b;
        end
    end
endmodule

// File: rtl/pmul_format.sv
// pmul_format: second stage. It turns the lane products into the selected
// result format and registers the result with its valid bit.
// Assumes an even lane count, so lanes pair up for the reduction.
module pmul_format
    import pmul_pkg::*;
#(
    parameter int LW    = 16,
    parameter int LANES = 4,
    localparam int PW    = 2 * LW,
    localparam int DW    = LW * LANES,
    localparam int PAIRS = LANES / 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    v_in,
    input  pmul_op_e                op,
    input  logic [LANES*PW-1:0]     prods,
    output logic                    valid_out,
    output logic [DW-1:0]           result_out
);
    logic [DW-1:0] fmt;

    // Select or reduce the products according to the captured opcode.
    always_comb begin
        fmt = '0;
        case (op)
            PM_LO: begin
                for (int i = 0; i < LANES; i++) begin
                    fmt[i*LW +: LW] = prods[i*PW +: LW];
                end
            end
            PM_HI: begin
                for (int i = 0; i < LANES; i++) begin
                    fmt[i*LW +: LW] = prods[i*PW+LW +: LW];
                end
            end
            PM_MADD: begin
                for (int j = 0; j < PAIRS; j++) begin
                    fmt[j*PW +: PW] = prods[(2*j)*PW +: PW] + prods[(2*j+1)*PW +: PW];
                end
            end
            default: fmt = '0;
        endcase
    end

    // Register the output strobe; reset drops anything in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
        end else begin
            valid_out <= v_in;
        end
    end

    // Register the formatted result on valid operations only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_out <= '0;
        end else if (v_in) begin
            result_out <= fmt;
        end
    end

    // R5: a reserved code in stage two must leave a zero result behind.
    assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (v_in && op == PM_RSVD) |=> (result_out == '0));
endmodule

// File: rtl/pmul_unit.sv
// pmul_unit: packed signed lane multiplier with low, high and pair-sum
// formats. Stage one registers the lane products together with the opcode
// and valid bit; stage two formats and registers the result. Latency is
// two cycles, and the unit takes a new operation every cycle.
module pmul_unit
    import pmul_pkg::*;
#(
    parameter int LW    = 16,
    parameter int LANES = 4,
    localparam int PW    = 2 * LW,
    localparam int DW    = LW * LANES,
    localparam int PAIRS = LANES / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          valid_in,
    input  logic [1:0]    op_in,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] b_in,
    output logic          valid_out,
    output logic [DW-1:0] result_out
);
    logic                v1_q;
    pmul_op_e            op1_q;
    logic [LANES*PW-1:0] prods;

    // Carry the valid bit of stage one; reset clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q <= 1'b0;
        end else begin
            v1_q <= valid_in;
        end
    end

    // Keep the opcode next to its own products.
    always_ff @(posedge clk) begin
        if (valid_in) begin
            op1_q <= pmul_op_e'(op_in);
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pmul_lane #(.LW(LW)) u_lane (
            .clk    (clk),
            .en     (valid_in),
            .a      (a_in[g*LW +: LW]),
            .b      (b_in[g*LW +: LW]),
            .prod_q (prods[g*PW +: PW])
        );
    end

    pmul_format #(.LW(LW), .LANES(LANES)) u_format (
        .clk        (clk),
        .rst_n      (rst_n),
        .v_in       (v1_q),
        .op         (op1_q),
        .prods      (prods),
        .valid_out  (valid_out),
        .result_out (result_out)
    );

    // Independent lane products of the present inputs, used only by the checks.
    logic signed [PW-1:0] ref_p [LANES];
    logic        [LW-1:0] ref_lo [LANES];
    logic        [LW-1:0] ref_hi [LANES];
    logic        [PW-1:0] ref_s [PAIRS];
    for (genvar g = 0; g < LANES; g++) begin : g_ref
        assign ref_p[g]  = $signed(a_in[g*LW +: LW]) * $signed(b_in[g*LW +: LW]);
        assign ref_lo[g] = ref_p[g][LW-1:0];
        assign ref_hi[g] = ref_p[g][PW-1:LW];
    end
    for (genvar j = 0; j < PAIRS; j++) begin : g_refsum
        assign ref_s[j] = ref_p[2*j] + ref_p[2*j+1];
    end

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R1 and R9: low format equals the low half of the signed product.
        assert_low_lane_R1: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2) && $past(valid_in, 2) && $past(op_in, 2) == 2'b00)
            |-> (result_out[g*LW +: LW] == $past(ref_lo[g], 2)));
        // R2 and R9: high format equals the high half of the signed product.
        assert_high_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2) && $past(valid_in, 2) && $past(op_in, 2) == 2'b01)
            |-> (result_out[g*LW +: LW] == $past(ref_hi[g], 2)));
    end

    for (genvar j = 0; j < PAIRS; j++) begin : g_chks
        // R3 and R4: each pair sum equals the wrapped sum of two products.
        assert_pair_sum_R3: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(rst_n, 2) && $past(valid_in, 2) && $past(op_in, 2) == 2'b10)
            |-> (result_out[j*PW +: PW] == $past(ref_s[j], 2)));
    end

    // R6: a result appears exactly two edges after its issue.
    assert_latency_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(valid_in, 2)) |-> valid_out);
    // R6: no strobe without an issue two edges earlier.
    assert_no_spurious_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && !$past(valid_in, 2)) |-> !valid_out);
    // R8: a reset edge leaves the output strobe low.
    assert_reset_clear_R8: assert property (@(posedge clk)
        !rst_n |=> !valid_out);
endmodule

// File: tb/pmul_unit_bench.sv
module pmul_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [1:0]  op_in = 2'b00;
    logic [63:0] a_in = '0;
    logic [63:0] b_in = '0;
    logic        valid_out;
    logic [63:0] result_out;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    typedef struct {
        logic [63:0] res;
        int          due;
        string       req;
    } exp_t;
    exp_t q[$];
    exp_t e;

    always #10 clk = ~clk;

    pmul_unit u_pmul_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid_in   (valid_in),
        .op_in      (op_in),
        .a_in       (a_in),
        .b_in       (b_in),
        .valid_out  (valid_out),
        .result_out (result_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Model derived from R1..R5 and R9.
    function automatic logic [63:0] model(logic [63:0] a, logic [63:0] b, logic [1:0] op);
        logic signed [31:0] p [4];
        logic [63:0] r;
        r = '0;
        for (int i = 0; i < 4; i++) begin
            p[i] = $signed(a[16*i +: 16]) * $signed(b[16*i +: 16]);
        end
        case (op)
            2'b00: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][15:0];
            2'b01: for (int i = 0; i < 4; i++) r[16*i +: 16] = p[i][31:16];
            2'b10: begin
                r[31:0]  = p[0] + p[1];
                r[63:32] = p[2] + p[3];
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    task automatic send_exp(logic [63:0] a, logic [63:0] b, logic [1:0] op,
                            logic [63:0] expv, string req);
        @(negedge clk);
        a_in = a; b_in = b; op_in = op; valid_in = 1'b1;
        q.push_back('{expv, cyc + 2, req});
    endtask

    task automatic send(logic [63:0] a, logic [63:0] b, logic [1:0] op, string req);
        send_exp(a, b, op, model(a, b, op), req);
    endtask

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            valid_in = 1'b0;
        end
    endtask

    // Monitor: pop and compare each result, with its arrival cycle (R6).
    always @(negedge clk) begin
        if (rst_n && valid_out) begin
            if (q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R6: unexpected valid_out, result=%h, expected no output", result_out);
            end else begin
                e = q.pop_front();
                checks++;
                if (result_out !== e.res) begin
                    fails++;
                    $display("FAIL %s: result=%h expected=%h", e.req, result_out, e.res);
                end
                checks++;
                if (cyc != e.due) begin
                    fails++;
                    $display("FAIL R6: result arrived in cycle %0d expected %0d", cyc, e.due);
                end
            end
        end
    end

    initial begin
        #(20 * 100000);
        checks++; fails++;
        $display("FAIL R6: watchdog expired, %0d results outstanding, expected 0", q.size());
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        checks++;
        if (valid_out !== 1'b0) begin
            fails++;
            $display("FAIL R8: valid_out=%b in reset expected 0", valid_out);
        end
        rst_n = 1'b1;
        idle(2);

        // R1 low halves, R9 signed lanes
        send(64'h0003_FFFF_7FFF_1234, 64'h0005_FFFF_7FFF_0010, 2'b00, "R1");
        send(64'hFFFF_FFFF_8000_0100, 64'h0001_FFFF_8000_0100, 2'b00, "R9");
        idle(3);
        // R2 high halves, R9 signed lanes
        send(64'hFFFF_FFFF_7FFF_8000, 64'h0001_FFFF_7FFF_8000, 2'b01, "R9");
        send_exp(64'hFFFF_FFFF_0000_0000, 64'h0001_FFFF_0000_0000, 2'b01,
                 64'hFFFF_0000_0000_0000, "R2");
        idle(3);
        // R3 pair sums
        send(64'h0002_0003_0004_0005, 64'h0006_0007_0008_0009, 2'b10, "R3");
        send_exp(64'h0002_0003_0004_0005, 64'h0006_0007_0008_0009, 2'b10,
                 64'h0000_0021_0000_004D, "R3");
        send(64'hFFFF_7FFF_8000_0001, 64'h7FFF_7FFF_7FFF_FFFF, 2'b10, "R3");
        idle(2);
        // R4 wrap case
        send_exp(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 2'b10,
                 64'h8000_0000_8000_0000, "R4");
        idle(2);
        // R5 reserved code
        send_exp(64'h1234_5678_9ABC_DEF0, 64'h7FFF_8000_FFFF_0001, 2'b11, 64'h0, "R5");
        idle(3);
        // R7 back-to-back mixed formats
        for (int k = 0; k < 8; k++) begin
            send(64'h8001_7FFE_FF00_00FF + 64'(k), 64'h00FF_8000_0101_7F7F - 64'(k),
                 2'(k), "R7");
        end
        idle(3);

        // R8: reset drops an operation in flight
        send(64'h0001_0001_0001_0001, 64'h0002_0002_0002_0002, 2'b00, "R8");
        @(negedge clk);
        valid_in = 1'b0; rst_n = 1'b0;
        q.delete();
        @(negedge clk);
        checks++;
        if (valid_out !== 1'b0) begin
            fails++;
            $display("FAIL R8: valid_out=%b after reset edge expected 0", valid_out);
        end
        rst_n = 1'b1;
        idle(4);

        // Mixed traffic with gaps, all formats (R6, R7)
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(0, 3) == 0) begin
                idle(1);
            end else begin
                send({$urandom, $urandom}, {$urandom, $urandom},
                     2'($urandom_range(0, 3)), "R7");
            end
        end
        idle(5);
        checks++;
        if (q.size() != 0) begin
            fails++;
            $display("FAIL R6: %0d results missing expected 0", q.size());
        end
        summary();
        $finish;
    end
endmodule